// File: doc/BRIEF.md
# Quad-width compressed load/store expander

This combinational block translates 16-bit compressed quad-width (128-bit) memory instructions into their 32-bit base encodings. It sits in the decode path of a core whose widest register mode is 128 bits. A mode input says whether the core currently runs 128-bit code. In 128-bit mode the two load/store slots of the register quadrant and the two of the stack quadrant mean quad load and quad store. Outside that mode, those same slots belong to the double-precision float load/store forms, which a separate decoder handles.

Each of the four forms carries an unsigned offset that counts in 16-byte units, spread across non-adjacent instruction bits. The block gathers the offset, rebuilds the register numbers, and emits either an I-type quad load or an S-type quad store. A recognised flag tells the surrounding decoder whether the output is valid. When the flag is low, the output word is all zeros and the decoder uses its own path instead.

Top module: `rvq_expand`

## Requirements
- R1: With mode high, input bits [1:0]=00 and [15:13]=001 give an I-type word: opcode 0001111, funct3 010, rs1 = 8 + bits[9:7], rd = 8 + bits[4:2], recognised high.
- R2: For the register-quadrant forms, the byte offset is {bit10, bits[6:5], bits[12:11]} shifted left by 4. Bit 10 gives offset bit 8, bits[6:5] give offset bits 7:6, and bits[12:11] give offset bits 5:4.
- R3: With mode high, bits[1:0]=00 and [15:13]=101 give an S-type word: opcode 0100011, funct3 100, rs1 = 8 + bits[9:7], rs2 = 8 + bits[4:2]. The offset from R2 is split into imm[11:5] at word bits 31:25 and imm[4:0] at word bits 11:7.
- R4: With mode high, bits[1:0]=10 and [15:13]=001 give an I-type quad load with rs1 = 2 and rd = bits[11:7]. The offset is {bits[5:2], bit12, bit6} shifted left by 4.
- R5: With mode high, bits[1:0]=10 and [15:13]=101 give an S-type quad store with rs1 = 2 and rs2 = bits[6:2]. The offset is {bits[10:7], bits[12:11]} shifted left by 4.
- R6: With mode low, all four slots give recognised low and an all-zero output word.
- R7: Any other encoding gives recognised low and an all-zero output word. This covers other funct3 values, quadrants 01 and 11, and the zero word.
- R8: The offset is zero-extended into the 12-bit immediate. Even the largest offset leaves the top immediate bits clear, and the low four immediate bits are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Compressed instruction |
| mode128_i | input | 1 | High when the core runs in 128-bit mode |
| instr_o | output | 32 | Expanded instruction, zero when not recognised |
| valid_o | output | 1 | High when instr_i is one of the four quad forms |

## Verification
The offset is checked with one bit set at a time in each field position, so that a swapped or shifted field shows up as a wrong immediate bit. Offsets of all ones are also used; these probe zero extension and the S-type immediate split. Register fields are driven at their lowest and highest values to separate the 3-bit compressed registers (plus 8) from the 5-bit full registers. Every slot is also tried with mode low, and neighbouring funct3 values and quadrants are tried as well; these confirm that the recognised flag only covers the four forms.

// File: rtl/rvq_pkg.sv
package rvq_pkg;
  localparam int CW   = 16;
  localparam int IW   = 32;
  localparam int RW   = 5;
  localparam int IMMW = 12;
  localparam int CRW  = 3;

  localparam logic [1:0] QD_REG    = 2'b00;
  localparam logic [1:0] QD_SP     = 2'b10;
  localparam logic [2:0] F3_CLOAD  = 3'b001;
  localparam logic [2:0] F3_CSTORE = 3'b101;
  localparam logic [6:0] OP_LOADQ  = 7'b0001111;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [2:0] F3_LOADQ  = 3'b010;
  localparam logic [2:0] F3_STOREQ = 3'b100;
  localparam logic [RW-1:0] SP_REG = 5'd2;

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] word;
  } xlat_t;

  function automatic logic [IW-1:0] mk_itype(logic [IMMW-1:0] imm, logic [RW-1:0] rs1,
                                             logic [RW-1:0] rd);
    return {imm, rs1, F3_LOADQ, rd, OP_LOADQ};
  endfunction

  function automatic logic [IW-1:0] mk_stype(logic [IMMW-1:0] imm, logic [RW-1:0] rs1,
                                             logic [RW-1:0] rs2);
    return {imm[11:5], rs2, rs1, F3_STOREQ, imm[4:0], OP_STORE};
  endfunction

  function automatic logic [RW-1:0] creg(logic [CRW-1:0] r);
    return {2'b01, r};
  endfunction
endpackage

// File: rtl/rvq_reg_form.sv
module rvq_reg_form
  import rvq_pkg::*;
(
  input  logic [CW-1:0] instr_i,
  input  logic          mode128_i,
  output xlat_t         res_o
);
  logic [IMMW-1:0] off;
  logic [RW-1:0]   rs1, rdx;
  logic            is_ld, is_st;

  // scrambled 16-byte-scaled offset
  assign off   = {3'b000, instr_i[10], instr_i[6:5], instr_i[12:11], 4'b0000};
  assign rs1   = creg(instr_i[9:7]);
  assign rdx   = creg(instr_i[4:2]);
  assign is_ld = mode128_i && instr_i[1:0] == QD_REG && instr_i[15:13] == F3_CLOAD;
  assign is_st = mode128_i && instr_i[1:0] == QD_REG && instr_i[15:13] == F3_CSTORE;

  always_comb begin
    res_o = '0;
    if (is_ld) begin
      res_o.hit  = 1'b1;
      res_o.word = mk_itype(off, rs1, rdx);
    end else if (is_st) begin
      res_o.hit  = 1'b1;
      res_o.word = mk_stype(off, rs1, rdx);
    end
  end

  always_comb begin
    if (!$isunknown(instr_i)) begin
      a_r2_reg_low_zero: assert (!res_o.hit || (res_o.word[6:0] == OP_LOADQ ?
                                 res_o.word[23:20] == 4'd0 : res_o.word[10:7] == 4'd0))
        else $error("low offset bits set");
    end
  end
endmodule

// File: rtl/rvq_sp_form.sv
module rvq_sp_form
  import rvq_pkg::*;
(
  input  logic [CW-1:0] instr_i,
  input  logic          mode128_i,
  output xlat_t         res_o
);
  logic [IMMW-1:0] off_ld, off_st;
  logic            is_ld, is_st;

  assign off_ld = {2'b00, instr_i[5:2], instr_i[12], instr_i[6], 4'b0000};
  assign off_st = {2'b00, instr_i[10:7], instr_i[12:11], 4'b0000};
  assign is_ld  = mode128_i && instr_i[1:0] == QD_SP && instr_i[15:13] == F3_CLOAD;
  assign is_st  = mode128_i && instr_i[1:0] == QD_SP && instr_i[15:13] == F3_CSTORE;

  always_comb begin
    res_o = '0;
    if (is_ld) begin
      res_o.hit  = 1'b1;
      res_o.word = mk_itype(off_ld, SP_REG, instr_i[11:7]);
    end else if (is_st) begin
      res_o.hit  = 1'b1;
      res_o.word = mk_stype(off_st, SP_REG, instr_i[6:2]);
    end
  end

  always_comb begin
    if (!$isunknown(instr_i)) begin
      a_r4_sp_base: assert (!res_o.hit || res_o.word[19:15] == SP_REG)
        else $error("stack form base not sp");
    end
  end
endmodule

// File: rtl/rvq_expand.sv
module rvq_expand
  import rvq_pkg::*;
(
  input  logic [15:0] instr_i,
  input  logic        mode128_i,
  output logic [31:0] instr_o,
  output logic        valid_o
);
  xlat_t reg_res, sp_res;

  rvq_reg_form i_reg_form (.instr_i(instr_i), .mode128_i(mode128_i), .res_o(reg_res));
  rvq_sp_form  i_sp_form  (.instr_i(instr_i), .mode128_i(mode128_i), .res_o(sp_res));

  always_comb begin
    if (reg_res.hit)     instr_o = reg_res.word;
    else if (sp_res.hit) instr_o = sp_res.word;
    else                 instr_o = '0;
  end
  assign valid_o = reg_res.hit | sp_res.hit;

  always_comb begin
    if (!$isunknown({instr_i, mode128_i})) begin
      a_r7_one_form: assert ($onehot0({reg_res.hit, sp_res.hit}))
        else $error("two forms matched");
      a_r6_mode_off: assert (mode128_i || (!valid_o && instr_o == '0))
        else $error("output outside 128-bit mode");
      a_r7_slots: assert (!valid_o || (instr_i[0] == 1'b0 && instr_i[14:13] == 2'b01))
        else $error("recognised a foreign slot");
      a_r1_opcode: assert (!valid_o || instr_o[6:0] == OP_LOADQ || instr_o[6:0] == OP_STORE)
        else $error("bad opcode");
      a_r8_zero_ext: assert (!valid_o || instr_o[31:30] == 2'b00)
        else $error("immediate not zero-extended");
      a_r7_zero_out: assert (valid_o || instr_o == '0)
        else $error("nonzero output when not recognised");
    end
  end
endmodule

// File: tb/test_rvq_expand.sv
module test_rvq_expand;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic        mode128_i = 1'b0;
  logic [31:0] instr_o;
  logic        valid_o;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  rvq_expand i_rvq_expand (.instr_i(instr_i), .mode128_i(mode128_i),
                           .instr_o(instr_o), .valid_o(valid_o));

  // monitor: compares half a cycle after the driver updates
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      logic [32:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({valid_o, instr_o} !== e) begin
        errors++;
        $display("FAIL %s: got valid=%0b word=%08h, expected valid=%0b word=%08h",
                 t, valid_o, instr_o, e[32], e[31:0]);
      end
    end
  end

  task automatic drive(input logic [15:0] ins, input logic m, input logic v,
                       input logic [31:0] w, input string t);
    @(posedge clk);
    #1;
    instr_i   = ins;
    mode128_i = m;
    exp_q.push_back({v, w});
    tag_q.push_back(t);
  endtask

  function automatic logic [31:0] ld_w(logic [11:0] imm, logic [4:0] rs1, logic [4:0] rd);
    return {imm, rs1, 3'b010, rd, 7'b0001111};
  endfunction
  function automatic logic [31:0] st_w(logic [11:0] imm, logic [4:0] rs1, logic [4:0] rs2);
    return {imm[11:5], rs2, rs1, 3'b100, imm[4:0], 7'b0100011};
  endfunction

  function automatic logic [15:0] q0(logic [2:0] f3, logic [2:0] rs1p, logic [2:0] rp,
                                     logic [11:0] off);
    return {f3, off[5:4], off[8], rs1p, off[7:6], rp, 2'b00};
  endfunction
  function automatic logic [15:0] q2_ld(logic [4:0] rd, logic [11:0] off);
    return {3'b001, off[5], rd, off[4], off[9:6], 2'b10};
  endfunction
  function automatic logic [15:0] q2_st(logic [4:0] rs2, logic [11:0] off);
    return {3'b101, off[5:4], off[9:6], rs2, 2'b10};
  endfunction

  task automatic r0_ld(logic [2:0] a, logic [2:0] d, logic [11:0] off, string t);
    drive(q0(3'b001, a, d, off), 1'b1, 1'b1, ld_w(off, {2'b01, a}, {2'b01, d}), t);
  endtask
  task automatic r0_st(logic [2:0] a, logic [2:0] s, logic [11:0] off, string t);
    drive(q0(3'b101, a, s, off), 1'b1, 1'b1, st_w(off, {2'b01, a}, {2'b01, s}), t);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #6;
    // reset state: zero word is not a quad form (R7)
    checks++;
    if ({valid_o, instr_o} !== 33'd0) begin
      errors++;
      $display("FAIL R7 reset: got %09h, expected 0", {valid_o, instr_o});
    end
    rst_ni = 1'b1;

    r0_ld(3'd0, 3'd7, 12'h000, "R1 reg load min regs");
    r0_ld(3'd7, 3'd0, 12'h1f0, "R1 R8 reg load max offset");
    r0_ld(3'd2, 3'd5, 12'h010, "R2 bit4");
    r0_ld(3'd2, 3'd5, 12'h020, "R2 bit5");
    r0_ld(3'd2, 3'd5, 12'h040, "R2 bit6");
    r0_ld(3'd2, 3'd5, 12'h080, "R2 bit7");
    r0_ld(3'd2, 3'd5, 12'h100, "R2 bit8");
    r0_st(3'd6, 3'd1, 12'h1f0, "R3 R8 reg store max offset");
    r0_st(3'd1, 3'd6, 12'h0a0, "R3 reg store split");
    r0_st(3'd3, 3'd4, 12'h110, "R3 reg store bits 8 and 4");

    drive(q2_ld(5'd1, 12'h3f0), 1'b1, 1'b1, ld_w(12'h3f0, 5'd2, 5'd1), "R4 R8 sp load max");
    drive(q2_ld(5'd31, 12'h040), 1'b1, 1'b1, ld_w(12'h040, 5'd2, 5'd31), "R4 sp load bit6");
    drive(q2_ld(5'd9, 12'h010), 1'b1, 1'b1, ld_w(12'h010, 5'd2, 5'd9), "R4 sp load bit4");
    drive(q2_ld(5'd9, 12'h020), 1'b1, 1'b1, ld_w(12'h020, 5'd2, 5'd9), "R4 sp load bit5");
    drive(q2_st(5'd31, 12'h3f0), 1'b1, 1'b1, st_w(12'h3f0, 5'd2, 5'd31), "R5 R8 sp store max");
    drive(q2_st(5'd0, 12'h050), 1'b1, 1'b1, st_w(12'h050, 5'd2, 5'd0), "R5 sp store 050");
    drive(q2_st(5'd17, 12'h200), 1'b1, 1'b1, st_w(12'h200, 5'd2, 5'd17), "R5 sp store bit9");

    drive(q0(3'b001, 3'd1, 3'd2, 12'h1f0), 1'b0, 1'b0, 32'd0, "R6 reg load mode low");
    drive(q0(3'b101, 3'd1, 3'd2, 12'h1f0), 1'b0, 1'b0, 32'd0, "R6 reg store mode low");
    drive(q2_ld(5'd4, 12'h3f0), 1'b0, 1'b0, 32'd0, "R6 sp load mode low");
    drive(q2_st(5'd4, 12'h3f0), 1'b0, 1'b0, 32'd0, "R6 sp store mode low");

    drive(q0(3'b010, 3'd1, 3'd2, 12'h0f0), 1'b1, 1'b0, 32'd0, "R7 funct3 010");
    drive(q0(3'b011, 3'd1, 3'd2, 12'h0f0), 1'b1, 1'b0, 32'd0, "R7 funct3 011");
    drive(q0(3'b111, 3'd1, 3'd2, 12'h0f0), 1'b1, 1'b0, 32'd0, "R7 funct3 111");
    drive({3'b001, 13'h0a5c} | 16'h0001, 1'b1, 1'b0, 32'd0, "R7 quadrant 01");
    drive(16'hffff, 1'b1, 1'b0, 32'd0, "R7 all ones");
    drive(16'h0000, 1'b1, 1'b0, 32'd0, "R7 zero word");

    @(posedge clk);
    @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule